// File: doc/BRIEF.md
# Erasable Byte-Wide Program Store Model

This block is a synthesizable stand-in for a byte-wide, electrically programmed, ultraviolet-erasable read-only memory. It has two control lines, both active low, for the output path. One is a chip select that also puts the device into low-power standby. The other is an output gate that is meant to be shared across a bank of such devices. A third active-low strobe performs writes while a programming-voltage flag is raised. A separate high-voltage identification flag switches reads over to two fixed identity bytes.

Analog levels, supply current and optical erasure are not modelled. A synchronous bulk-erase input takes the place of optical erasure and sets every word to all ones in one cycle. The array depth is a parameter. The full-size part has 131,072 bytes (17 array address bits). The default build keeps a small array so that it elaborates quickly. Read data is registered, so a read appears one clock after the edge that samples it. The bidirectional data pins are split into a write-data input and a read-data output, plus a drive-enable. While the enable is low, the read-data output is held at zero.

Top module: `uv_eprom_model`

## Requirements
- R1: After synchronous reset, `dout_en` and `sig_err` are 0. This holds even when `e_n` and `g_n` go low in the first cycle after reset.
- R2: One cycle with `bulk_erase` high sets every word to FFh. Erase takes priority over a write in the same cycle.
- R3: A write replaces the stored word with the bitwise AND of the old word and `din`. A write can clear bits but can never set a 0 back to 1.
- R4: A write takes place at a clock edge only when `vpp_prog`=1, `e_n`=0 and `p_n`=0. If `vpp_prog` is 0, or if `p_n` is 1, the array is unchanged. While the strobe is low, the outputs are not driven on the following cycle.
- R5: With `vpp_prog`=1 and `e_n`=1, a low `p_n` writes nothing, and the outputs stay undriven.
- R6: With `e_n`=0, `g_n`=0 and neither the write condition nor the identification mode active, the word at `addr[ARRAY_AW-1:0]` appears on `dout` one clock after the sampling edge, with `dout_en`=1. A new address shows its data one clock later.
- R7: Whenever `e_n` is 1, `dout_en` is 0 and `dout` is 0 in the same cycle, whatever `g_n` is.
- R8: With `e_n`=0 and `g_n`=1, `dout_en` is 0 and `dout` is 0.
- R9: With `vpp_prog`=1, `e_n`=0, `g_n`=0 and `p_n`=1, the array word is read back with the same one-clock latency as a normal read.
- R10: With `id_hv`=1 and `vpp_prog`=0, a read returns 20h when `addr[0]`=0 and 05h when `addr[0]`=1, whatever the array holds. With `vpp_prog`=1, `id_hv` has no effect.
- R11: `sig_err` is 1 one clock after an edge at which `id_hv`=1, `vpp_prog`=0, `e_n`=0 and any bit of `addr` above bit 0 is 1. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Data applied for a write |
| dout | output | 8 | Read data, zero when not driven |
| dout_en | output | 1 | Drive enable for the data pins |
| e_n | input | 1 | Chip select and power control, active low |
| g_n | input | 1 | Output gate, active low |
| p_n | input | 1 | Write strobe, active low |
| vpp_prog | input | 1 | Programming supply is at write level |
| id_hv | input | 1 | Identification high-voltage line is raised |
| bulk_erase | input | 1 | Set every word to FFh |
| sig_err | output | 1 | Identification read was made with a stray high address bit |

## Verification
Three kinds of result arrive at three different times. Read data, identity bytes and `sig_err` are registered, so they are due one clock after the edge that samples the inputs. Array contents change at the write edge and can be seen only through a read one edge later. The gating of `dout_en` by `e_n` and `g_n` acts within the same cycle. The bench drives inputs on the falling edge. It samples registered results on the falling edge that follows the rising edge that captured them. It checks the same-cycle gating 1 ns after changing a control, before any rising edge occurs. An idle cycle between scenarios keeps a stale registered enable from leaking into the next check.

// File: rtl/eprom_pkg.sv
`timescale 1ns/1ps
package eprom_pkg;

    localparam int unsigned BYTE_W = 8;

    localparam logic [BYTE_W-1:0] MAKER_ID = 8'h20;
    localparam logic [BYTE_W-1:0] PART_ID  = 8'h05;
    localparam logic [BYTE_W-1:0] BLANK    = 8'hFF;

    // Operating condition decoded from the control lines
    typedef enum logic [2:0] {
        OP_STANDBY,
        OP_INHIBIT,
        OP_OUT_OFF,
        OP_READ,
        OP_PROGRAM,
        OP_VERIFY,
        OP_IDENT
    } op_e;

    // Control bundle passed from decoder to array and output stage
    typedef struct packed {
        logic wr;       // burn din into the addressed word
        logic rd;       // capture a read result this edge
        logic ident;    // read result is an identity byte
        logic id_sel;   // which identity byte
        logic id_bad;   // identification read with stray address bit
    } ctl_t;

    function automatic logic [BYTE_W-1:0] ident_byte(input logic sel);
        return sel ? PART_ID : MAKER_ID;
    endfunction

    // Cells can only be driven from 1 to 0
    function automatic logic [BYTE_W-1:0] burn(input logic [BYTE_W-1:0] old_w,
                                                input logic [BYTE_W-1:0] new_w);
        return old_w & new_w;
    endfunction

endpackage

// File: rtl/eprom_ctl_dec.sv
`timescale 1ns/1ps
module eprom_ctl_dec
    import eprom_pkg::*;
#(
    parameter int unsigned ADDR_W = 17
) (
    input  logic              e_n,
    input  logic              g_n,
    input  logic              p_n,
    input  logic              vpp_prog,
    input  logic              id_hv,
    input  logic [ADDR_W-1:0] addr,
    output ctl_t              ctl
);

    op_e  op;
    logic stray_hi;

    assign stray_hi = |addr[ADDR_W-1:1];

    always_comb begin
        if (e_n) begin
            op = vpp_prog ? OP_INHIBIT : OP_STANDBY;
        end else if (vpp_prog) begin
            if (!p_n)      op = OP_PROGRAM;
            else if (!g_n) op = OP_VERIFY;
            else           op = OP_OUT_OFF;
        end else if (g_n) begin
            op = OP_OUT_OFF;
        end else if (id_hv) begin
            op = OP_IDENT;
        end else begin
            op = OP_READ;
        end
    end

    always_comb begin
        ctl.wr     = (op == OP_PROGRAM);
        ctl.rd     = (op == OP_READ) || (op == OP_VERIFY) || (op == OP_IDENT);
        ctl.ident  = (op == OP_IDENT);
        ctl.id_sel = addr[0];
        ctl.id_bad = !e_n && id_hv && !vpp_prog && stray_hi;
    end

endmodule

// File: rtl/eprom_cell_array.sv
`timescale 1ns/1ps
module eprom_cell_array
    import eprom_pkg::*;
#(
    parameter int unsigned ARRAY_AW = 9
) (
    input  logic                clk,
    input  logic                erase,
    input  logic                wr,
    input  logic [ARRAY_AW-1:0] waddr,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [BYTE_W-1:0]   rdata
);

    localparam int unsigned DEPTH = 1 << ARRAY_AW;

    logic [BYTE_W-1:0] cells [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        logic [BYTE_W-1:0] word_q;
        logic              hit;

        assign hit = wr && (waddr == ARRAY_AW'(w));

        always_ff @(posedge clk) begin
            if (erase) begin
                word_q <= BLANK;
            end else if (hit) begin
                word_q <= burn(word_q, wdata);
            end
        end

        assign cells[w] = word_q;
    end

    assign rdata = cells[waddr];

endmodule

// File: rtl/eprom_out_stage.sv
`timescale 1ns/1ps
module eprom_out_stage
    import eprom_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic [BYTE_W-1:0] arr_rd,
    input  logic              e_n,
    input  logic              g_n,
    output logic [BYTE_W-1:0] dout,
    output logic              dout_en,
    output logic              sig_err
);

    logic [BYTE_W-1:0] data_q;
    logic              drive_q;
    logic              err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            drive_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            drive_q <= ctl.rd;
            err_q   <= ctl.id_bad;
            if (ctl.rd) begin
                data_q <= ctl.ident ? ident_byte(ctl.id_sel) : arr_rd;
            end
        end
    end

    // Both control lines release the bus at once, without waiting a clock
    assign dout_en = drive_q && !e_n && !g_n;
    assign dout    = dout_en ? data_q : '0;
    assign sig_err = err_q;

endmodule

// File: rtl/uv_eprom_model.sv
`timescale 1ns/1ps
module uv_eprom_model
    import eprom_pkg::*;
#(
    parameter int unsigned ADDR_W   = 17,
    parameter int unsigned ARRAY_AW = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en,
    input  logic              e_n,
    input  logic              g_n,
    input  logic              p_n,
    input  logic              vpp_prog,
    input  logic              id_hv,
    input  logic              bulk_erase,
    output logic              sig_err
);

    ctl_t              ctl;
    logic [BYTE_W-1:0] arr_rd;

    eprom_ctl_dec #(.ADDR_W(ADDR_W)) u_dec (
        .e_n      (e_n),
        .g_n      (g_n),
        .p_n      (p_n),
        .vpp_prog (vpp_prog),
        .id_hv    (id_hv),
        .addr     (addr),
        .ctl      (ctl)
    );

    eprom_cell_array #(.ARRAY_AW(ARRAY_AW)) u_array (
        .clk   (clk),
        .erase (bulk_erase),
        .wr    (ctl.wr),
        .waddr (addr[ARRAY_AW-1:0]),
        .wdata (din),
        .rdata (arr_rd)
    );

    eprom_out_stage u_out (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .arr_rd  (arr_rd),
        .e_n     (e_n),
        .g_n     (g_n),
        .dout    (dout),
        .dout_en (dout_en),
        .sig_err (sig_err)
    );

endmodule

// File: rtl/eprom_model_chk.sv
`timescale 1ns/1ps
module eprom_model_chk #(
    parameter int unsigned ADDR_W = 17
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              e_n,
    input logic              g_n,
    input logic              p_n,
    input logic              vpp_prog,
    input logic              id_hv,
    input logic              bulk_erase,
    input logic [7:0]        dout,
    input logic              dout_en,
    input logic              sig_err
);

    // R7
    standby_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        e_n |-> (!dout_en && dout == 8'h00));

    // R8
    gate_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!e_n && g_n) |-> !dout_en);

    // R6
    read_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (!e_n && !g_n && !(vpp_prog && !p_n)) ##1 (!e_n && !g_n) |-> dout_en);

    // R4
    burn_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (vpp_prog && !e_n && !p_n) |=> !dout_en);

    // R2
    erase_blank_chk: assert property (@(posedge clk) disable iff (rst)
        bulk_erase ##1 (!e_n && !g_n && !vpp_prog && !id_hv) ##1 (!e_n && !g_n)
        |-> dout == 8'hFF);

    // R10
    maker_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (id_hv && !vpp_prog && !e_n && !g_n && !addr[0]) ##1 (!e_n && !g_n)
        |-> dout == 8'h20);

    // R10
    part_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (id_hv && !vpp_prog && !e_n && !g_n && addr[0]) ##1 (!e_n && !g_n)
        |-> dout == 8'h05);

    // R11
    stray_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (id_hv && !vpp_prog && !e_n && (|addr[ADDR_W-1:1])) |=> sig_err);

    // R11
    clean_addr_chk: assert property (@(posedge clk) disable iff (rst)
        !(id_hv && !vpp_prog && !e_n && (|addr[ADDR_W-1:1])) |=> !sig_err);

endmodule

bind uv_eprom_model eprom_model_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .e_n        (e_n),
    .g_n        (g_n),
    .p_n        (p_n),
    .vpp_prog   (vpp_prog),
    .id_hv      (id_hv),
    .bulk_erase (bulk_erase),
    .dout       (dout),
    .dout_en    (dout_en),
    .sig_err    (sig_err)
);

// File: tb/uv_eprom_model_bench.sv
`timescale 1ns/1ps
module uv_eprom_model_bench;

    localparam int unsigned ADDR_W   = 17;
    localparam int unsigned ARRAY_AW = 9;
    localparam int unsigned LIMIT    = 200000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        din = '0;
    logic [7:0]        dout;
    logic              dout_en;
    logic              e_n = 1'b1;
    logic              g_n = 1'b1;
    logic              p_n = 1'b1;
    logic              vpp_prog = 1'b0;
    logic              id_hv = 1'b0;
    logic              bulk_erase = 1'b0;
    logic              sig_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    uv_eprom_model #(.ADDR_W(ADDR_W), .ARRAY_AW(ARRAY_AW)) u_uv_eprom_model (
        .clk        (clk),
        .rst        (rst),
        .addr       (addr),
        .din        (din),
        .dout       (dout),
        .dout_en    (dout_en),
        .e_n        (e_n),
        .g_n        (g_n),
        .p_n        (p_n),
        .vpp_prog   (vpp_prog),
        .id_hv      (id_hv),
        .bulk_erase (bulk_erase),
        .sig_err    (sig_err)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        e_n = 1'b1; g_n = 1'b1; p_n = 1'b1; vpp_prog = 1'b0;
        id_hv = 1'b0; bulk_erase = 1'b0; din = '0; addr = '0;
        cyc();
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic vpp, input logic id,
                      output logic [7:0] q, output logic en);
        addr = a; vpp_prog = vpp; id_hv = id; e_n = 1'b0; g_n = 1'b0; p_n = 1'b1;
        cyc();
        q = dout; en = dout_en;
        e_n = 1'b1; g_n = 1'b1; vpp_prog = 1'b0; id_hv = 1'b0;
    endtask

    task automatic pr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        addr = a; din = d; vpp_prog = 1'b1; e_n = 1'b0; g_n = 1'b1; p_n = 1'b0;
        cyc();
        p_n = 1'b1; vpp_prog = 1'b0; e_n = 1'b1;
    endtask

    task automatic t_reset();
        e_n = 1'b0; g_n = 1'b0;
        #1;
        check("R1 dout_en after reset", {7'b0, dout_en}, 8'h00);
        check("R1 sig_err after reset", {7'b0, sig_err}, 8'h00);
        e_n = 1'b1; g_n = 1'b1;
        cyc();
    endtask

    task automatic t_erase();
        logic [7:0] q; logic en;
        idle();
        bulk_erase = 1'b1;
        cyc();
        bulk_erase = 1'b0;
        rd(17'd0, 1'b0, 1'b0, q, en);
        check("R2 word 0 blank", q, 8'hFF);
        rd(17'd511, 1'b0, 1'b0, q, en);
        check("R2 last word blank", q, 8'hFF);
        // erase beats a write in the same cycle
        addr = 17'd85; din = 8'h00; vpp_prog = 1'b1; e_n = 1'b0; p_n = 1'b0;
        bulk_erase = 1'b1;
        cyc();
        bulk_erase = 1'b0; p_n = 1'b1; vpp_prog = 1'b0; e_n = 1'b1;
        rd(17'd85, 1'b0, 1'b0, q, en);
        check("R2 erase over write", q, 8'hFF);
    endtask

    task automatic t_burn();
        logic [7:0] q; logic en;
        idle();
        pr(17'd5, 8'hA5);
        rd(17'd5, 1'b0, 1'b0, q, en);
        check("R3 first burn", q, 8'hA5);
        pr(17'd5, 8'h3C);
        rd(17'd5, 1'b0, 1'b0, q, en);
        check("R3 second burn ANDs", q, 8'h24);
        pr(17'd5, 8'hFF);
        rd(17'd5, 1'b0, 1'b0, q, en);
        check("R3 ones cannot be restored", q, 8'h24);
        rd(17'd6, 1'b0, 1'b0, q, en);
        check("R3 neighbour untouched", q, 8'hFF);
    endtask

    task automatic t_no_burn();
        logic [7:0] q; logic en;
        idle();
        addr = 17'd10; din = 8'h00; vpp_prog = 1'b0; e_n = 1'b0; p_n = 1'b0;
        cyc();
        p_n = 1'b1; e_n = 1'b1;
        rd(17'd10, 1'b0, 1'b0, q, en);
        check("R4 no write without vpp_prog", q, 8'hFF);
        addr = 17'd10; din = 8'h00; vpp_prog = 1'b1; e_n = 1'b0; p_n = 1'b1;
        cyc();
        vpp_prog = 1'b0; e_n = 1'b1;
        rd(17'd10, 1'b0, 1'b0, q, en);
        check("R4 no write with p_n high", q, 8'hFF);
        // strobe low with gate low: bus not driven next cycle
        addr = 17'd12; din = 8'hF0; vpp_prog = 1'b1; e_n = 1'b0; g_n = 1'b0; p_n = 1'b0;
        cyc();
        check("R4 undriven during write", {7'b0, dout_en}, 8'h00);
        idle();
    endtask

    task automatic t_inhibit();
        logic [7:0] q; logic en;
        idle();
        addr = 17'd11; din = 8'h00; vpp_prog = 1'b1; e_n = 1'b1; g_n = 1'b0; p_n = 1'b0;
        cyc();
        check("R5 inhibited part undriven", {7'b0, dout_en}, 8'h00);
        idle();
        rd(17'd11, 1'b0, 1'b0, q, en);
        check("R5 inhibited word unchanged", q, 8'hFF);
    endtask

    task automatic t_read();
        idle();
        pr(17'd20, 8'h5A);
        pr(17'd21, 8'h96);
        idle();
        addr = 17'd20; e_n = 1'b0; g_n = 1'b0;
        #1;
        check("R6 not driven before first edge", {7'b0, dout_en}, 8'h00);
        cyc();
        check("R6 read data", dout, 8'h5A);
        check("R6 read enable", {7'b0, dout_en}, 8'h01);
        addr = 17'd21;
        #1;
        check("R6 old data held until edge", dout, 8'h5A);
        cyc();
        check("R6 new address data", dout, 8'h96);
        // upper bits above the array are not part of the word index
        addr = 17'h10014;
        cyc();
        check("R6 index uses low address bits", dout, 8'h5A);
    endtask

    task automatic t_standby();
        e_n = 1'b1;
        #1;
        check("R7 standby releases same cycle", {7'b0, dout_en}, 8'h00);
        check("R7 standby dout zero", dout, 8'h00);
        cyc();
        check("R7 standby with gate low", {7'b0, dout_en}, 8'h00);
        g_n = 1'b1;
        cyc();
        check("R7 standby with gate high", {7'b0, dout_en}, 8'h00);
    endtask

    task automatic t_gate();
        idle();
        addr = 17'd20; e_n = 1'b0; g_n = 1'b1;
        cyc();
        check("R8 gate high undriven", {7'b0, dout_en}, 8'h00);
        check("R8 gate high dout zero", dout, 8'h00);
        g_n = 1'b0;
        cyc();
        check("R8 gate low drives next cycle", {7'b0, dout_en}, 8'h01);
        g_n = 1'b1;
        #1;
        check("R8 gate release same cycle", {7'b0, dout_en}, 8'h00);
    endtask

    task automatic t_verify();
        logic [7:0] q; logic en;
        idle();
        rd(17'd20, 1'b1, 1'b0, q, en);
        check("R9 verify data", q, 8'h5A);
        check("R9 verify enable", {7'b0, en}, 8'h01);
    endtask

    task automatic t_ident();
        logic [7:0] q; logic en;
        idle();
        pr(17'd0, 8'h00);
        pr(17'd1, 8'h00);
        rd(17'd0, 1'b0, 1'b1, q, en);
        check("R10 maker byte", q, 8'h20);
        rd(17'd1, 1'b0, 1'b1, q, en);
        check("R10 part byte", q, 8'h05);
        rd(17'd20, 1'b1, 1'b1, q, en);
        check("R10 id_hv ignored when vpp_prog", q, 8'h5A);
    endtask

    task automatic t_ident_err();
        idle();
        e_n = 1'b0; g_n = 1'b0; id_hv = 1'b1; addr = 17'h00100;
        cyc();
        check("R11 stray bit 8", {7'b0, sig_err}, 8'h01);
        addr = 17'h00001;
        cyc();
        check("R11 only bit 0 clean", {7'b0, sig_err}, 8'h00);
        addr = 17'h10000;
        cyc();
        check("R11 stray top bit", {7'b0, sig_err}, 8'h01);
        id_hv = 1'b0; addr = 17'h00100;
        cyc();
        check("R11 no flag outside ident", {7'b0, sig_err}, 8'h00);
        idle();
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_erase();
        t_burn();
        t_no_burn();
        t_inhibit();
        t_read();
        t_standby();
        t_gate();
        t_verify();
        t_ident();
        t_ident_err();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule